// File: doc/BRIEF.md
# Task Priority Shadow Access Unit

This block resolves a guest's read or write of the 4-bit task-priority control register while virtualization controls are in force. Each request is classified by four plain control inputs (a 64-bit-mode flag, an exit-on-load control, an exit-on-store control and a use-shadow control). It then has one of four outcomes. It may access the real priority register, or access a 32-bit shadow word that stands for four consecutive bytes of a virtual interrupt-controller page. It may also ask for an exit to the host, or raise an undefined-instruction fault.

Requests enter on a valid/ready channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the single response register is empty or is being drained in the same cycle. The response of an accepted request appears on the next cycle. It stays valid and unchanged until `rsp_ready` is seen high, so a consumer may stall indefinitely. Control inputs are sampled at the accepting edge. A one-cycle `shadow_written` strobe accompanies every shadow write, so that a later priority-threshold check can hook in.

Top module: `tps_access_unit`

## Requirements
- R1: After reset the shadow word and the real priority register are zero, `rsp_valid` and `shadow_written` are low, and `req_ready` is high.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request's response is valid on the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged and no request is taken.
- R3: A request taken while the 64-bit flag is low yields kind 3 (fault) with read data zero. It changes neither the shadow word nor the priority register, whatever the other controls are.
- R4: In 64-bit mode, a read with exit-on-store 0 and use-shadow 0 yields kind 0 (normal), with read data bits 3:0 equal to the real priority register and bits 63:4 zero.
- R5: In 64-bit mode, a write with exit-on-load 0 and use-shadow 0 yields kind 0. It loads write data bits 3:0 into the real priority register and leaves the shadow word unchanged.
- R6: In 64-bit mode, a read with exit-on-store 0 and use-shadow 1 yields kind 1 (shadow), with read data bits 3:0 equal to shadow bits 7:4 and bits 63:4 zero.
- R7: In 64-bit mode, a write with exit-on-load 0 and use-shadow 1 yields kind 1. It sets shadow bits 7:4 to write data bits 3:0, clears shadow bits 3:0 and 31:8, and leaves the priority register unchanged.
- R8: In 64-bit mode, a read with exit-on-store 1 yields kind 2 (exit) with read data zero and no state change, regardless of use-shadow. Exit-on-load has no effect on reads.
- R9: In 64-bit mode, a write with exit-on-load 1 yields kind 2 with no state change, regardless of use-shadow. Exit-on-store has no effect on writes.
- R10: `shadow_written` is high for exactly the cycle in which the response of a shadow write is first presented, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | Requester is in 64-bit mode |
| ctl_load_exit | input | 1 | Writes to the priority register exit to the host |
| ctl_store_exit | input | 1 | Reads of the priority register exit to the host |
| ctl_use_shadow | input | 1 | Redirect accesses to the shadow word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Source operand of a write; bits 3:0 carry the priority |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_kind | output | 2 | 0 normal, 1 shadow, 2 exit, 3 fault |
| rsp_is_write | output | 1 | Echo of the request direction |
| rsp_rdata | output | 64 | Read result; zero for writes, exits and faults |
| shadow_word | output | 32 | Current shadow word (byte 0 in bits 7:0) |
| prio_value | output | 4 | Current real priority register |
| shadow_written | output | 1 | One-cycle strobe after a shadow write |

## Verification
The hardest situation to reach is a stalled response with a second request waiting behind it. The stalled request must not reach the state, even though its controls would call for a write. The bench holds `rsp_ready` low and presents a normal write to the priority register for a full cycle. It then checks that the first response and the register are both unchanged, before releasing the stall and watching the write land one cycle later. The bits that a shadow write clears are never set by any legal path, so the bench checks the clearing through the exact full-word value after writes whose upper source bits are all ones.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_SHADOW = 2'd1,
    OUT_EXIT   = 2'd2,
    OUT_FAULT  = 2'd3
  } tps_outcome_e;
endpackage

// File: rtl/tps_decode.sv
module tps_decode
  import tps_pkg::*;
(
  input  logic         is_write,
  input  logic         mode64,
  input  logic         load_exit,
  input  logic         store_exit,
  input  logic         use_shadow,
  output tps_outcome_e outcome
);
  logic exit_sel;

  // The exit control that matters depends on direction only.
  assign exit_sel = is_write ? load_exit : store_exit;

  // Priority: mode fault, then host exit, then shadow, then normal.
  always_comb begin
    if (!mode64)         outcome = OUT_FAULT;
    else if (exit_sel)   outcome = OUT_EXIT;
    else if (use_shadow) outcome = OUT_SHADOW;
    else                 outcome = OUT_NORMAL;
  end
endmodule

// File: rtl/tps_state.sv
module tps_state
  import tps_pkg::*;
#(
  parameter int SHADOW_W = 32,
  parameter int PRIO_W   = 4,
  parameter int NIB_LSB  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                is_write,
  input  tps_outcome_e        outcome,
  input  logic [PRIO_W-1:0]   wr_prio,
  output logic [SHADOW_W-1:0] shadow_q,
  output logic [PRIO_W-1:0]   prio_q,
  output logic                shadow_wr_q
);
  localparam int NIB_MSB = NIB_LSB + PRIO_W - 1;

  logic do_prio_wr;
  logic do_shadow_wr;
  logic [SHADOW_W-1:0] shadow_next;

  assign do_prio_wr   = accept && is_write && (outcome == OUT_NORMAL);
  assign do_shadow_wr = accept && is_write && (outcome == OUT_SHADOW);

  // The new shadow word holds only the priority nibble; all else clears.
  always_comb begin
    shadow_next = '0;
    shadow_next[NIB_MSB:NIB_LSB] = wr_prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q    <= '0;
      prio_q      <= '0;
      shadow_wr_q <= 1'b0;
    end else begin
      shadow_wr_q <= do_shadow_wr;
      if (do_shadow_wr) shadow_q <= shadow_next;
      if (do_prio_wr)   prio_q   <= wr_prio;
    end
  end

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && outcome == OUT_FAULT) |=> ($stable(shadow_q) && $stable(prio_q))); // R3
  AST_EXIT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && outcome == OUT_EXIT) |=> ($stable(shadow_q) && $stable(prio_q))); // R9
  AST_SHADOW_WR_KEEPS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_write && outcome == OUT_SHADOW) |=> $stable(prio_q)); // R7
  AST_NORMAL_WR_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_write && outcome == OUT_NORMAL) |=> $stable(shadow_q)); // R5
endmodule

// File: rtl/tps_resp.sv
module tps_resp
  import tps_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  tps_outcome_e      outcome,
  input  logic [PRIO_W-1:0] prio_cur,
  input  logic [PRIO_W-1:0] shadow_nib,
  input  logic              rsp_ready,
  output logic              can_take,
  output logic              rsp_valid,
  output tps_outcome_e      rsp_kind,
  output logic              rsp_is_write,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] rdata_next;

  assign can_take = !rsp_valid || rsp_ready;

  // Reads return a nibble in the low bits; everything else returns zero.
  always_comb begin
    rdata_next = '0;
    if (!is_write) begin
      if (outcome == OUT_NORMAL)      rdata_next[PRIO_W-1:0] = prio_cur;
      else if (outcome == OUT_SHADOW) rdata_next[PRIO_W-1:0] = shadow_nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_kind     <= OUT_NORMAL;
      rsp_is_write <= 1'b0;
      rsp_rdata    <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_kind     <= outcome;
      rsp_is_write <= is_write;
      rsp_rdata    <= rdata_next;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_rdata)
                                   && $stable(rsp_is_write))); // R2
  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R2
endmodule

// File: rtl/tps_access_unit.sv
module tps_access_unit
  import tps_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SHADOW_W = 32,
  parameter int PRIO_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode64,
  input  logic                ctl_load_exit,
  input  logic                ctl_store_exit,
  input  logic                ctl_use_shadow,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_is_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [1:0]          rsp_kind,
  output logic                rsp_is_write,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [SHADOW_W-1:0] shadow_word,
  output logic [PRIO_W-1:0]   prio_value,
  output logic                shadow_written
);
  // Priority nibble sits in the upper half of shadow byte 0.
  localparam int NIB_LSB = 8 - PRIO_W;
  localparam int NIB_MSB = 7;

  tps_outcome_e outcome;
  tps_outcome_e kind_q;
  logic         accept;
  logic         can_take;
  logic         unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:PRIO_W];
  assign req_ready = can_take;
  assign accept    = req_valid && can_take;
  assign rsp_kind  = kind_q;

  tps_decode u_decode (
    .is_write   (req_is_write),
    .mode64     (mode64),
    .load_exit  (ctl_load_exit),
    .store_exit (ctl_store_exit),
    .use_shadow (ctl_use_shadow),
    .outcome    (outcome)
  );

  tps_state #(
    .SHADOW_W (SHADOW_W),
    .PRIO_W   (PRIO_W),
    .NIB_LSB  (NIB_LSB)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .is_write    (req_is_write),
    .outcome     (outcome),
    .wr_prio     (req_wdata[PRIO_W-1:0]),
    .shadow_q    (shadow_word),
    .prio_q      (prio_value),
    .shadow_wr_q (shadow_written)
  );

  tps_resp #(
    .DATA_W (DATA_W),
    .PRIO_W (PRIO_W)
  ) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .is_write     (req_is_write),
    .outcome      (outcome),
    .prio_cur     (prio_value),
    .shadow_nib   (shadow_word[NIB_MSB:NIB_LSB]),
    .rsp_ready    (rsp_ready),
    .can_take     (can_take),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (kind_q),
    .rsp_is_write (rsp_is_write),
    .rsp_rdata    (rsp_rdata)
  );

  AST_STROBE_WITH_SHADOW_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_written |-> (rsp_valid && kind_q == OUT_SHADOW && rsp_is_write)); // R10
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (kind_q == OUT_FAULT || kind_q == OUT_EXIT)) |-> (rsp_rdata == '0)); // R8
  AST_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:PRIO_W] == '0)); // R6
endmodule

// File: tb/tps_access_unit_tb.sv
module tps_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode64 = 1'b1;
  logic        ctl_load_exit = 1'b0;
  logic        ctl_store_exit = 1'b0;
  logic        ctl_use_shadow = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic        rsp_is_write;
  logic [63:0] rsp_rdata;
  logic [31:0] shadow_word;
  logic [3:0]  prio_value;
  logic        shadow_written;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tps_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .ctl_load_exit(ctl_load_exit), .ctl_store_exit(ctl_store_exit),
    .ctl_use_shadow(ctl_use_shadow),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_is_write(rsp_is_write), .rsp_rdata(rsp_rdata),
    .shadow_word(shadow_word), .prio_value(prio_value),
    .shadow_written(shadow_written)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge, let it be taken, sample after.
  task automatic issue(input bit w, input logic [63:0] d, input bit m64,
                       input bit le, input bit se, input bit us);
    @(negedge clk);
    req_is_write = w; req_wdata = d; mode64 = m64;
    ctl_load_exit = le; ctl_store_exit = se; ctl_use_shadow = us;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(rsp_valid == 1'b0, "R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check(shadow_word == 32'd0, "R1 shadow", {32'd0, shadow_word}, 64'd0);
    check(prio_value == 4'd0, "R1 prio", {60'd0, prio_value}, 64'd0);
    check(shadow_written == 1'b0, "R1 strobe", {63'd0, shadow_written}, 64'd0);
    check(req_ready == 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_normal();
    issue(1'b1, 64'hFFFF_FFFF_FFFF_FFF5, 1'b1, 1'b0, 1'b0, 1'b0);
    check(rsp_valid && rsp_kind == 2'd0, "R5 kind", {62'd0, rsp_kind}, 64'd0);
    check(prio_value == 4'h5, "R5 prio", {60'd0, prio_value}, 64'h5);
    check(shadow_word == 32'd0, "R5 shadow", {32'd0, shadow_word}, 64'd0);
    check(rsp_rdata == 64'd0, "R5 write data", rsp_rdata, 64'd0);
    issue(1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(rsp_kind == 2'd0 && !rsp_is_write, "R4 kind", {62'd0, rsp_kind}, 64'd0);
    check(rsp_rdata == 64'h5, "R4 rdata", rsp_rdata, 64'h5);
  endtask

  task automatic t_shadow();
    issue(1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b1);
    check(rsp_kind == 2'd1, "R7 kind", {62'd0, rsp_kind}, 64'd1);
    check(shadow_word == 32'h0000_00C0, "R7 shadow", {32'd0, shadow_word}, 64'hC0);
    check(prio_value == 4'h5, "R7 prio kept", {60'd0, prio_value}, 64'h5);
    check(shadow_written == 1'b1, "R10 strobe high", {63'd0, shadow_written}, 64'd1);
    @(negedge clk);
    check(shadow_written == 1'b0, "R10 strobe low", {63'd0, shadow_written}, 64'd0);
    issue(1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    check(rsp_kind == 2'd1, "R6 kind", {62'd0, rsp_kind}, 64'd1);
    check(rsp_rdata == 64'hC, "R6 rdata", rsp_rdata, 64'hC);
    check(shadow_written == 1'b0, "R10 no strobe on read", {63'd0, shadow_written}, 64'd0);
    issue(1'b1, 64'hFFFF_FFFF_FFFF_FFF3, 1'b1, 1'b0, 1'b0, 1'b1);
    check(shadow_word == 32'h0000_0030, "R7 rewrite", {32'd0, shadow_word}, 64'h30);
  endtask

  task automatic t_exit();
    issue(1'b0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    check(rsp_kind == 2'd2, "R8 read exit", {62'd0, rsp_kind}, 64'd2);
    check(rsp_rdata == 64'd0, "R8 rdata", rsp_rdata, 64'd0);
    issue(1'b0, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    check(rsp_kind == 2'd1, "R8 load ctl ignored", {62'd0, rsp_kind}, 64'd1);
    check(rsp_rdata == 64'h3, "R8 shadow data", rsp_rdata, 64'h3);
    issue(1'b1, 64'hA, 1'b1, 1'b1, 1'b0, 1'b1);
    check(rsp_kind == 2'd2, "R9 write exit", {62'd0, rsp_kind}, 64'd2);
    check(shadow_word == 32'h30, "R9 shadow kept", {32'd0, shadow_word}, 64'h30);
    check(shadow_written == 1'b0, "R9 no strobe", {63'd0, shadow_written}, 64'd0);
    issue(1'b1, 64'hA, 1'b1, 1'b1, 1'b0, 1'b0);
    check(prio_value == 4'h5, "R9 prio kept", {60'd0, prio_value}, 64'h5);
    issue(1'b1, 64'h7, 1'b1, 1'b0, 1'b1, 1'b0);
    check(rsp_kind == 2'd0, "R9 store ctl ignored", {62'd0, rsp_kind}, 64'd0);
    check(prio_value == 4'h7, "R9 normal write", {60'd0, prio_value}, 64'h7);
  endtask

  task automatic t_fault();
    issue(1'b1, 64'hE, 1'b0, 1'b0, 1'b0, 1'b1);
    check(rsp_kind == 2'd3, "R3 write fault", {62'd0, rsp_kind}, 64'd3);
    check(shadow_word == 32'h30, "R3 shadow kept", {32'd0, shadow_word}, 64'h30);
    check(shadow_written == 1'b0, "R3 no strobe", {63'd0, shadow_written}, 64'd0);
    issue(1'b1, 64'hE, 1'b0, 1'b0, 1'b0, 1'b0);
    check(prio_value == 4'h7, "R3 prio kept", {60'd0, prio_value}, 64'h7);
    issue(1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(rsp_kind == 2'd3 && rsp_rdata == 64'd0, "R3 read fault", rsp_rdata, 64'd0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(rsp_valid && rsp_rdata == 64'h7, "R2 first rsp", rsp_rdata, 64'h7);
    check(req_ready == 1'b0, "R2 ready low", {63'd0, req_ready}, 64'd0);
    req_is_write = 1'b1; req_wdata = 64'h9; req_valid = 1'b1;
    @(negedge clk);
    check(rsp_valid && rsp_kind == 2'd0 && !rsp_is_write && rsp_rdata == 64'h7,
          "R2 held", rsp_rdata, 64'h7);
    check(prio_value == 4'h7, "R2 not taken", {60'd0, prio_value}, 64'h7);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_is_write, "R2 second rsp", {63'd0, rsp_is_write}, 64'd1);
    check(prio_value == 4'h9, "R2 write lands", {60'd0, prio_value}, 64'h9);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 drained", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_shadow();
    t_exit();
    t_fault();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule